// File: doc/BRIEF.md
# Critical-Word-First Burst Master

This block sits on the processor-bus side of a host bridge. It takes memory requests that come in from an I/O bus and turns each one into a single cache-block burst on the processor bus. A request carries a kind and a 32-bit byte address. The kind is read or write, locked or not, and for writes whether the data will invalidate the whole line. Once the block accepts a request, it drives a 5-bit transfer-type code, a burst strobe and the 3-bit burst size code. These hold steady for the whole burst.

A burst moves one 32-byte block as four 64-bit double-word beats. The first beat carries the double word the request points at. Later beats step upward through the block and wrap past its end back to the start, so a request aimed at double word 2 moves 2, 3, 0, 1. Each beat waits on a per-beat acknowledge. After the fourth acknowledge the block gives a one-cycle completion pulse and is ready for a new request. Arbitration, snooping, the data path and single-beat transfers are handled elsewhere.

Top module: `cwf_burst_master`

## Requirements
- R1: After reset, and with no burst running, `req_ready` is 1, while `beat_valid`, `burst_done`, `burst_strobe`, `xfer_type`, `size_code` and `beat_addr` are all 0.
- R2: While a burst runs, `burst_strobe` is 1 and `size_code` is 3'b010.
- R3: `xfer_type` is chosen as follows: read unlocked 5'b01010, read locked 5'b11110, write unlocked 5'b00010, write locked 5'b10010, write with `req_inval`=1 5'b00110 whether locked or not. `req_inval` has no effect on a read.
- R4: On every beat, `beat_addr[31:5]` equals the accepted request's bits 31:5 and `beat_addr[2:0]` is 0. The first beat's bits 4:3 equal the request's bits 4:3, whatever the request's bits 2:0.
- R5: Each acknowledged beat is followed by the next double word: bits 4:3 go up by one modulo 4. A start at 2 gives the order 2,3,0,1.
- R6: While `beat_ack` is 0, the current beat and its address hold unchanged.
- R7: The cycle after the fourth acknowledge, `burst_done` is 1 for exactly one cycle, `beat_valid` is 0 and `req_ready` is 1.
- R8: While a burst runs, `req_ready` is 0 and `req_valid` is ignored: the type and address of the running burst do not change.
- R9: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) shows its first beat from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Locked (atomic) request |
| req_inval | input | 1 | Write that invalidates the whole line |
| req_addr | input | 32 | Request byte address |
| req_ready | output | 1 | Block is idle and can take a request |
| xfer_type | output | 5 | Processor-bus transfer-type code |
| burst_strobe | output | 1 | Burst indication |
| size_code | output | 3 | Transfer size code |
| beat_addr | output | 32 | Address of the current double-word beat |
| beat_valid | output | 1 | A beat is waiting for acknowledge |
| beat_ack | input | 1 | Current beat completed |
| burst_done | output | 1 | One-cycle pulse after the last beat |

## Verification
Some rules are checked on every cycle by the assertions. These are: the strobe and size code seen during a burst, zero low address bits, beats that hold still while unacknowledged, a one-step wrapping advance on each acknowledge, no acceptance while busy, and a done pulse that lasts one cycle. Other behaviour only shows up in the bench's scenarios. That covers the type code chosen for each request kind, and the full beat order for each start position. It also covers a request that points mid-double-word, a request raised during a running burst, and a new request issued in the same cycle as the completion pulse.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  localparam int TT_W   = 5;
  localparam int SIZE_W = 3;

  localparam logic [TT_W-1:0] TT_WR_FLUSH      = 5'b00010;
  localparam logic [TT_W-1:0] TT_WR_FLUSH_ATOM = 5'b10010;
  localparam logic [TT_W-1:0] TT_WR_KILL       = 5'b00110;
  localparam logic [TT_W-1:0] TT_RD_BURST      = 5'b01010;
  localparam logic [TT_W-1:0] TT_RD_OWN_ATOM   = 5'b11110;

  localparam logic [SIZE_W-1:0] SIZE_BLOCK = 3'b010;

  typedef struct packed {
    logic write;
    logic locked;
    logic inval;
  } req_kind_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/cwf_rst_sync.sv
module cwf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cwf_type_sel.sv
module cwf_type_sel
  import cwf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  req_kind_t       kind,
  output logic [TT_W-1:0] tt_q
);

  logic [TT_W-1:0] tt_code;
  logic [TT_W-1:0] tt_d;

  // invalidate only matters for writes; it outranks the lock bit
  always_comb begin
    if (kind.write) begin
      if (kind.inval)       tt_code = TT_WR_KILL;
      else if (kind.locked) tt_code = TT_WR_FLUSH_ATOM;
      else                  tt_code = TT_WR_FLUSH;
    end else begin
      if (kind.locked)      tt_code = TT_RD_OWN_ATOM;
      else                  tt_code = TT_RD_BURST;
    end
  end

  always_comb begin
    tt_d = tt_q;
    if (load) tt_d = tt_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tt_q <= '0;
    else        tt_q <= tt_d;
  end

endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             beat_ack,
  output logic             busy,
  output logic             load,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          cnt_d   = '0;
          state_d = ST_BEAT;
        end
      end
      ST_BEAT: begin
        if (beat_ack) begin
          if (cnt_q == LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q == ST_BEAT);

endmodule

// File: rtl/cwf_addr_gen.sv
module cwf_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int BEAT_BYTES  = 8,
  localparam int OFF_W = $clog2(BEAT_BYTES),
  localparam int BLK_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = BLK_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  cnt,
  output logic [ADDR_W-1:0] beat_addr
);

  logic [ADDR_W-BLK_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]        start_q, start_d;
  logic [IDX_W-1:0]        idx;

  always_comb begin
    base_d  = base_q;
    start_d = start_q;
    if (load) begin
      base_d  = req_addr[ADDR_W-1:BLK_W];
      start_d = req_addr[BLK_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
    end else begin
      base_q  <= base_d;
      start_q <= start_d;
    end
  end

  // modulo add gives the wrap inside the block
  assign idx = start_q + cnt;

  always_comb begin
    if (busy) beat_addr = {base_q, idx, {OFF_W{1'b0}}};
    else      beat_addr = '0;
  end

endmodule

// File: rtl/cwf_burst_master.sv
module cwf_burst_master
  import cwf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int BEAT_BYTES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_locked,
  input  logic              req_inval,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic [4:0]        xfer_type,
  output logic              burst_strobe,
  output logic [2:0]        size_code,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_valid,
  input  logic              beat_ack,
  output logic              burst_done
);

  localparam int BEATS = BLOCK_BYTES / BEAT_BYTES;
  localparam int CNT_W = $clog2(BEATS);

  logic             rst_sync_n;
  logic             busy;
  logic             load;
  logic             acc_valid;
  logic [CNT_W-1:0] cnt;
  logic [TT_W-1:0]  tt_q;
  req_kind_t        kind;

  cwf_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign acc_valid = req_valid & rst_sync_n;
  assign kind      = '{write: req_write, locked: req_locked, inval: req_inval};

  cwf_ctrl #(.BEATS(BEATS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (acc_valid),
    .beat_ack  (beat_ack),
    .busy      (busy),
    .load      (load),
    .cnt_q     (cnt),
    .done_q    (burst_done)
  );

  cwf_type_sel type_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (load),
    .kind  (kind),
    .tt_q  (tt_q)
  );

  cwf_addr_gen #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES),
    .BEAT_BYTES  (BEAT_BYTES)
  ) addr_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .busy      (busy),
    .req_addr  (req_addr),
    .cnt       (cnt),
    .beat_addr (beat_addr)
  );

  assign req_ready    = ~busy & rst_sync_n;
  assign beat_valid   = busy;
  assign burst_strobe = busy;
  assign size_code    = busy ? SIZE_BLOCK : '0;
  assign xfer_type    = busy ? tt_q : '0;

endmodule

// File: rtl/cwf_burst_master_chk.sv
module cwf_burst_master_chk #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int BEAT_BYTES  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [4:0]        xfer_type,
  input logic              burst_strobe,
  input logic [2:0]        size_code,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_valid,
  input logic              beat_ack,
  input logic              burst_done
);

  localparam int OFF_W = $clog2(BEAT_BYTES);
  localparam int BLK_W = $clog2(BLOCK_BYTES);

  a_r2_strobe_size: assert property (@(posedge clk) disable iff (!rst_n)
    burst_strobe |-> size_code == 3'b010);

  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_addr[OFF_W-1:0] == '0);

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ack) |=>
      (burst_done || beat_addr[BLK_W-1:OFF_W] == $past(beat_addr[BLK_W-1:OFF_W]) + 1'b1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ack) |=> (beat_valid && $stable(beat_addr)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> (!beat_valid && req_ready));

  a_r8_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  a_r8_stable_type: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && $past(beat_valid)) |->
      ($stable(xfer_type) && $stable(beat_addr[ADDR_W-1:BLK_W])));

  a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> beat_valid);

endmodule

bind cwf_burst_master cwf_burst_master_chk #(
  .ADDR_W      (ADDR_W),
  .BLOCK_BYTES (BLOCK_BYTES),
  .BEAT_BYTES  (BEAT_BYTES)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .xfer_type    (xfer_type),
  .burst_strobe (burst_strobe),
  .size_code    (size_code),
  .beat_addr    (beat_addr),
  .beat_valid   (beat_valid),
  .beat_ack     (beat_ack),
  .burst_done   (burst_done)
);

// File: tb/cwf_burst_master_tb.sv
module cwf_burst_master_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic        req_locked;
  logic        req_inval;
  logic [31:0] req_addr;
  logic        req_ready;
  logic [4:0]  xfer_type;
  logic        burst_strobe;
  logic [2:0]  size_code;
  logic [31:0] beat_addr;
  logic        beat_valid;
  logic        beat_ack;
  logic        burst_done;

  int total = 0;
  int bad   = 0;

  cwf_burst_master dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_locked   (req_locked),
    .req_inval    (req_inval),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .xfer_type    (xfer_type),
    .burst_strobe (burst_strobe),
    .size_code    (size_code),
    .beat_addr    (beat_addr),
    .beat_valid   (beat_valid),
    .beat_ack     (beat_ack),
    .burst_done   (burst_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_tt(input logic w, input logic l, input logic i);
    if (w && i)  return 5'b00110;
    if (w && l)  return 5'b10010;
    if (w)       return 5'b00010;
    if (l)       return 5'b11110;
    return 5'b01010;
  endfunction

  task automatic check_idle(input string req);
    check({req, " ready"},  {31'd0, req_ready},    32'd1);
    check({req, " valid"},  {31'd0, beat_valid},   32'd0);
    check({req, " strobe"}, {31'd0, burst_strobe}, 32'd0);
    check({req, " size"},   {29'd0, size_code},    32'd0);
    check({req, " type"},   {27'd0, xfer_type},    32'd0);
    check({req, " addr"},   beat_addr,             32'd0);
  endtask

  // one full burst; wait_cyc idle cycles before every ack; intrude raises a second request mid-burst
  task automatic run_burst(input logic w, input logic l, input logic i,
                           input logic [31:0] a, input int wait_cyc, input bit intrude);
    logic [4:0] tt;
    tt = exp_tt(w, l, i);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_locked = l; req_inval = i; req_addr = a;
    check("R8 ready before accept", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~w; req_locked = ~l; req_inval = ~i; req_addr = ~a;
    check("R9 first beat", {31'd0, beat_valid}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] ea;
      ea = {a[31:5], 2'(a[4:3] + 2'(k)), 3'b000};
      for (int c = 0; c < wait_cyc; c++) begin
        if (intrude && k == 1) begin
          req_valid = 1'b1; req_addr = a ^ 32'h0000_1018; req_write = ~w; req_locked = ~l;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 held beat", beat_addr, ea);
        if (intrude && k == 1) begin
          check("R8 busy ready", {31'd0, req_ready}, 32'd0);
          check("R8 type unchanged", {27'd0, xfer_type}, {27'd0, tt});
        end
      end
      check("R4 R5 beat addr", beat_addr, ea);
      check("R3 type", {27'd0, xfer_type}, {27'd0, tt});
      check("R2 strobe", {31'd0, burst_strobe}, 32'd1);
      check("R2 size", {29'd0, size_code}, 32'd2);
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end
    check("R7 done", {31'd0, burst_done}, 32'd1);
    check("R7 valid low", {31'd0, beat_valid}, 32'd0);
    check("R7 ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    check("R7 done one cycle", {31'd0, burst_done}, 32'd0);
    check_idle("R1 idle after burst");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_locked = 1'b0;
    req_inval = 1'b0; req_addr = '0; beat_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    check("R1 done", {31'd0, burst_done}, 32'd0);
  endtask

  task automatic t_kinds;
    run_burst(1'b0, 1'b0, 1'b0, 32'h1234_5650, 0, 1'b0);
    run_burst(1'b0, 1'b1, 1'b0, 32'h8000_0008, 0, 1'b0);
    run_burst(1'b1, 1'b0, 1'b0, 32'hA5A5_A5E0, 0, 1'b0);
    run_burst(1'b1, 1'b1, 1'b0, 32'h0000_0018, 1, 1'b0);
    run_burst(1'b1, 1'b0, 1'b1, 32'hFFFF_FFF0, 0, 1'b0);
    run_burst(1'b1, 1'b1, 1'b1, 32'h4000_0040, 0, 1'b0);
    run_burst(1'b0, 1'b0, 1'b1, 32'h0BAD_F00D, 0, 1'b0);  // R3 inval ignored, R4 unaligned low bits
    run_burst(1'b0, 1'b1, 1'b1, 32'h7777_7777, 2, 1'b0);
  endtask

  task automatic t_wrap_order;
    // R5 start at double word 2: 2,3,0,1
    run_burst(1'b0, 1'b0, 1'b0, 32'h0000_0110, 3, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_burst(1'b1, 1'b0, 1'b0, 32'h2222_2208, 2, 1'b1);
    @(negedge clk);
    check("R8 no late accept", {31'd0, beat_valid}, 32'd0);
  endtask

  task automatic t_back_to_back;
    // new request in the done cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_locked = 1'b0; req_inval = 1'b0;
    req_addr = 32'h3000_0018;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check("R5 b2b order", beat_addr, {27'h180_0000, 2'(2'd3 + 2'(k)), 3'b000});
      beat_ack = 1'b1;
      if (k == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_locked = 1'b1; req_addr = 32'h3000_0020;
      end
      @(negedge clk);
      beat_ack = 1'b0;
      if (k == 3) check("R7 ready in done cycle", {31'd0, req_ready}, 32'd1);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second burst", beat_addr, 32'h3000_0020);
    check("R3 b2b type", {27'd0, xfer_type}, 32'h12);
    for (int k = 0; k < 4; k++) begin
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end
    check("R7 b2b done", {31'd0, burst_done}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_kinds();
    t_wrap_order();
    t_busy_ignore();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule